// File: doc/BRIEF.md
# SPI Mode-3 Register Read Slave

This block lets an application processor, acting as SPI master, read a small register space inside a chip. It runs entirely on the system clock. The SPI clock, chip select and data-in pins are synchronised and edge-detected, so no logic is clocked by the SPI clock. The first byte of every chip-select window is a command. A read command is followed by one dummy byte. Read data then streams out on MISO, most significant bit first.

Two registers can be read. A version register always returns the same constant. A data port pops bytes from a byte FIFO with show-ahead output, which sits outside this block. A single transaction may read as many data bytes as the master clocks. Write commands are decoded and then ignored, because no register is writable.

The controller is a six-state machine:
- IDLE: chip select is high.
- CMD: the command byte is being received.
- DUMMY: the dummy byte is being received.
- VER: the version byte is being served.
- DATA: FIFO bytes are being served.
- SINK: every later byte returns zeros.

The transitions are:
- IDLE to CMD when chip select goes low.
- CMD to DUMMY on a complete read command naming the version or data register.
- CMD to SINK on a write command or an unknown register.
- DUMMY to VER or DATA, depending on the latched register field.
- VER to SINK after one byte.
- DATA stays in DATA until chip select rises.
- Any state to IDLE whenever chip select is high.

Top module: `spi_rd_slave`

## Requirements
- R1: SPI mode 3. MOSI is sampled on rising SCLK edges and MISO changes only after falling SCLK edges. Both directions carry the most significant bit first, so FIFO bytes 0x80 and 0x01 arrive unchanged.
- R2: The first byte after chip select falls is the command. Its bit 7 = 1 means read and bit 7 = 0 means write.
- R3: Command bits 6:4 select the register: 000 is version and 010 is data. Bits 3:0 are ignored, so 0x8F reads the version register just as 0x80 does.
- R4: MISO carries 0x00 during the command byte and during the dummy byte that follows a read command.
- R5: A version read returns 0x10 in the first byte after the dummy. It returns 0x00 in any later byte of the same transaction and pops nothing.
- R6: A data read (0xA0) returns the FIFO bytes in order. It pops exactly one entry for each data byte the master starts to clock.
- R7: A write command (bit 7 = 0) returns 0x00 on every byte, pops nothing and leaves the FIFO contents intact.
- R8: A data byte started while the FIFO is empty reads 0x00 and pops nothing. A pop is never issued while the FIFO reports empty.
- R9: A read of any register code other than 000 or 010 returns 0x00 on every byte and pops nothing.
- R10: MISO is 0 whenever chip select has been high for four or more system clocks.
- R11: Raising chip select discards a partial byte. The next transaction is decoded from its own first byte.
- R12: During and right after reset, MISO and the pop strobe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk_i | input | 1 | SPI serial clock from the master, idle high |
| spi_cs_n_i | input | 1 | Active-low chip select |
| spi_mosi_i | input | 1 | Serial data from the master |
| spi_miso_o | output | 1 | Serial data to the master |
| fifo_empty_i | input | 1 | FIFO holds no byte |
| fifo_data_i | input | DATA_W | Head entry of the show-ahead FIFO |
| fifo_pop_o | output | 1 | One-cycle strobe that removes the FIFO head |

## Verification
The assertions assume an idle-high SCLK that runs no faster than a quarter of the system clock. They also assume chip select changes only while SCLK is high and that MOSI is stable around each rising edge. Under these conditions a falling-edge detection never coincides with the state change caused by the preceding byte.

The stimulus keeps within these limits. It holds each SCLK phase for six system clocks and moves chip select only with SCLK high, after a settling gap. It changes MOSI only together with the falling SCLK edge. The only deliberate violation is a chip-select rise after three bits, which exercises the abort path.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;

    // controller states, one per phase of a chip-select window
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DUMMY,
        ST_VER,
        ST_DATA,
        ST_SINK
    } ctl_state_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= d_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[s] <= RST_VAL;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              cs_act,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_done_o,
    output logic              byte_start_o,
    output logic              sclk_fall_o,
    output logic              miso_o
);

    localparam int unsigned IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    logic              sclk_prev;
    logic              rise;
    logic              fall;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    logic              miso_q;

    assign rise = cs_act &  sclk_s & ~sclk_prev;
    assign fall = cs_act & ~sclk_s &  sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_prev <= 1'b1;
        else        sclk_prev <= sclk_s;
    end

    // receive side: sample on rising edge, count bits of the current byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_idx <= '0;
            rx_sh   <= '0;
        end else if (!cs_act) begin
            bit_idx <= '0;
        end else if (rise) begin
            rx_sh   <= {rx_sh[DATA_W-2:0], mosi_s};
            bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + 1'b1;
        end
    end

    // transmit side: new byte taken on the first falling edge of a byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (!cs_act) begin
            tx_sh  <= '0;
            miso_q <= 1'b0;
        end else if (fall) begin
            if (bit_idx == '0) begin
                miso_q <= tx_byte_i[DATA_W-1];
                tx_sh  <= {tx_byte_i[DATA_W-2:0], 1'b0};
            end else begin
                miso_q <= tx_sh[DATA_W-1];
                tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    assign rx_byte_o    = {rx_sh[DATA_W-2:0], mosi_s};
    assign rx_done_o    = rise && (bit_idx == LAST_IDX);
    assign byte_start_o = fall && (bit_idx == '0);
    assign sclk_fall_o  = fall;
    assign miso_o       = miso_q;

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_rd_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned REG_W       = 3,
    parameter logic [DATA_W-1:0] VERSION_VAL = 8'h10,
    parameter logic [REG_W-1:0]  VER_ADDR    = 3'd0,
    parameter logic [REG_W-1:0]  DATA_ADDR   = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              byte_start,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              pop_o,
    output ctl_state_e        state_o
);

    localparam int unsigned RW_BIT  = DATA_W - 1;
    localparam int unsigned REG_TOP = DATA_W - 2;

    ctl_state_e       state;
    ctl_state_e       nxt;
    logic [REG_W-1:0] reg_sel;
    logic [REG_W-1:0] cmd_reg;
    logic             cmd_read;

    assign cmd_read = rx_byte[RW_BIT];
    assign cmd_reg  = rx_byte[REG_TOP -: REG_W];

    // state register plus latched register field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            reg_sel <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CMD && rx_done) reg_sel <= cmd_reg;
        end
    end

    always_comb begin
        nxt = state;
        if (!cs_act) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_CMD;
                ST_CMD: begin
                    if (rx_done) begin
                        if (cmd_read && (cmd_reg == VER_ADDR || cmd_reg == DATA_ADDR))
                            nxt = ST_DUMMY;
                        else
                            nxt = ST_SINK;
                    end
                end
                ST_DUMMY: begin
                    if (rx_done) nxt = (reg_sel == DATA_ADDR) ? ST_DATA : ST_VER;
                end
                ST_VER:   if (rx_done) nxt = ST_SINK;
                ST_DATA:  nxt = ST_DATA;
                ST_SINK:  nxt = ST_SINK;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // outputs: byte offered at the next byte start, and the pop strobe
    always_comb begin
        tx_byte_o = '0;
        pop_o     = 1'b0;
        unique case (state)
            ST_VER:  tx_byte_o = VERSION_VAL;
            ST_DATA: begin
                tx_byte_o = fifo_empty_i ? '0 : fifo_data_i;
                pop_o     = byte_start & ~fifo_empty_i;
            end
            default: begin
                tx_byte_o = '0;
                pop_o     = 1'b0;
            end
        endcase
    end

    assign state_o = state;

endmodule

// File: rtl/spi_rd_slave.sv
module spi_rd_slave
    import spi_rd_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned REG_W       = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] VERSION_VAL = 8'h10,
    parameter logic [REG_W-1:0]  VER_ADDR    = 3'd0,
    parameter logic [REG_W-1:0]  DATA_ADDR   = 3'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sclk_i,
    input  logic              spi_cs_n_i,
    input  logic              spi_mosi_i,
    output logic              spi_miso_o,
    input  logic              fifo_empty_i,
    input  logic [DATA_W-1:0] fifo_data_i,
    output logic              fifo_pop_o
);

    localparam int unsigned PIN_N = 3;
    localparam logic [PIN_N-1:0] PIN_RST = 3'b110; // {sclk, cs_n, mosi}

    logic [PIN_N-1:0]  pins_s;
    logic              sclk_s;
    logic              cs_n_s;
    logic              mosi_s;
    logic              cs_act;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_done;
    logic              byte_start;
    logic              sclk_fall;
    logic              miso_q;
    logic [DATA_W-1:0] tx_byte;
    ctl_state_e        state;

    spi_pin_sync #(
        .WIDTH  (PIN_N),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({spi_sclk_i, spi_cs_n_i, spi_mosi_i}),
        .q_o  (pins_s)
    );

    assign sclk_s = pins_s[2];
    assign cs_n_s = pins_s[1];
    assign mosi_s = pins_s[0];
    assign cs_act = ~cs_n_s;

    spi_bit_engine #(
        .DATA_W(DATA_W)
    ) u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sclk_s),
        .mosi_s      (mosi_s),
        .cs_act      (cs_act),
        .tx_byte_i   (tx_byte),
        .rx_byte_o   (rx_byte),
        .rx_done_o   (rx_done),
        .byte_start_o(byte_start),
        .sclk_fall_o (sclk_fall),
        .miso_o      (miso_q)
    );

    spi_cmd_ctrl #(
        .DATA_W     (DATA_W),
        .REG_W      (REG_W),
        .VERSION_VAL(VERSION_VAL),
        .VER_ADDR   (VER_ADDR),
        .DATA_ADDR  (DATA_ADDR)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_act      (cs_act),
        .rx_done     (rx_done),
        .rx_byte     (rx_byte),
        .byte_start  (byte_start),
        .fifo_empty_i(fifo_empty_i),
        .fifo_data_i (fifo_data_i),
        .tx_byte_o   (tx_byte),
        .pop_o       (fifo_pop_o),
        .state_o     (state)
    );

    assign spi_miso_o = cs_act & miso_q;

endmodule

// File: rtl/spi_rd_slave_chk.sv
module spi_rd_slave_chk
    import spi_rd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n_i,
    input logic       spi_miso_o,
    input logic       fifo_pop_o,
    input logic       fifo_empty_i,
    input logic       cs_act,
    input logic       sclk_fall,
    input ctl_state_e state
);

    // R8: never pop an empty FIFO
    assert_pop_needs_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |-> !fifo_empty_i);

    // R6: at most one pop per byte start, so never on two cycles in a row
    assert_pop_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop_o |=> !fifo_pop_o);

    // R10: MISO low once chip select has been high for four clocks
    assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n_i && $past(spi_cs_n_i) && $past(spi_cs_n_i, 2) && $past(spi_cs_n_i, 3))
        |-> !spi_miso_o);

    // R1: MISO moves only after a falling SCLK edge or a deselect
    assert_miso_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_miso_o) |-> ($past(sclk_fall) || $fell(cs_act)));

    // R7, R9: write / unknown register sink never pops
    assert_sink_no_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SINK) |-> !fifo_pop_o);

    // R5: version phase never pops
    assert_version_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VER) |-> !fifo_pop_o);

    // R11: deselect returns the decoder to idle on the next clock
    assert_deselect_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (state == ST_IDLE));

endmodule

bind spi_rd_slave spi_rd_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_cs_n_i  (spi_cs_n_i),
    .spi_miso_o  (spi_miso_o),
    .fifo_pop_o  (fifo_pop_o),
    .fifo_empty_i(fifo_empty_i),
    .cs_act      (cs_act),
    .sclk_fall   (sclk_fall),
    .state       (state)
);

// File: tb/sim_spi_rd_slave.sv
`timescale 1ns/1ps
module sim_spi_rd_slave;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic       miso;
    logic       fifo_empty = 1'b1;
    logic [7:0] fifo_data = 8'h00;
    logic       fifo_pop;

    int tests = 0;
    int fails = 0;
    int pop_cnt = 0;
    int cs_high_cnt = 0;
    bit pend_pop = 0;
    bit monitor_on = 0;
    logic [7:0] fifo_q[$];

    always #2.5 clk = ~clk;

    spi_rd_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_sclk_i  (sclk),
        .spi_cs_n_i  (cs_n),
        .spi_mosi_i  (mosi),
        .spi_miso_o  (miso),
        .fifo_empty_i(fifo_empty),
        .fifo_data_i (fifo_data),
        .fifo_pop_o  (fifo_pop)
    );

    function automatic void refresh();
        fifo_empty = (fifo_q.size() == 0);
        fifo_data  = (fifo_q.size() != 0) ? fifo_q[0] : 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural FIFO and per-clock comparisons
    always @(negedge clk) begin
        if (pend_pop) begin
            if (fifo_q.size() != 0) void'(fifo_q.pop_front());
            pend_pop = 0;
            refresh();
        end
        if (fifo_pop) begin
            pend_pop = 1;
            pop_cnt++;
        end
        cs_high_cnt = cs_n ? cs_high_cnt + 1 : 0;
        if (monitor_on) begin
            check("R8 pop while empty", {31'd0, fifo_pop & fifo_empty}, 32'd0);
            if (cs_high_cnt >= 4) check("R10 miso idle", {31'd0, miso}, 32'd0);
        end
    end

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        fifo_q.push_back(b);
        refresh();
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            sclk = 1'b0;
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    // one transaction: command, dummy, then n data bytes, compared to model
    task automatic txn(input logic [7:0] cmd, input int n, input string req);
        logic [7:0] rx;
        logic [7:0] exp;
        int         pops0;
        int         exp_pops;
        logic [7:0] snap[$];
        snap = fifo_q;
        pops0 = pop_cnt;
        exp_pops = 0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        xfer(cmd, rx);
        check({req, " R4 cmd byte"}, {24'd0, rx}, 32'd0);
        xfer(8'hFF, rx);
        check({req, " R4 second byte"}, {24'd0, rx}, 32'd0);
        for (int k = 0; k < n; k++) begin
            exp = 8'h00;
            if (cmd[7]) begin
                if (cmd[6:4] == 3'b000) exp = (k == 0) ? 8'h10 : 8'h00;
                else if (cmd[6:4] == 3'b010) begin
                    if (k < snap.size()) begin
                        exp = snap[k];
                        exp_pops++;
                    end
                end
            end
            xfer(8'h00, rx);
            check(req, {24'd0, rx}, {24'd0, exp});
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        check({req, " pop count"}, pop_cnt - pops0, exp_pops);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rx;
        refresh();
        repeat (3) @(negedge clk);
        check("R12 miso in reset", {31'd0, miso}, 32'd0);
        check("R12 pop in reset", {31'd0, fifo_pop}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R12 miso after reset", {31'd0, miso}, 32'd0);
        check("R12 pop after reset", {31'd0, fifo_pop}, 32'd0);
        monitor_on = 1;

        // R6 R1 R2: data stream, bit order patterns
        push(8'h80); push(8'h01); push(8'hA5);
        txn(8'hA0, 3, "R6 R1 R2 data read");
        check("R6 fifo drained", fifo_q.size(), 0);

        // R5: version then zero
        txn(8'h80, 2, "R5 version read");
        // R3: low command bits ignored
        txn(8'h8F, 1, "R3 version 0x8F");

        // R7: write ignored, FIFO kept
        push(8'h3C); push(8'hC3);
        txn(8'h20, 3, "R7 write cmd");
        check("R7 fifo intact", fifo_q.size(), 2);
        txn(8'hA0, 2, "R7 data after write");

        // R8: empty FIFO
        txn(8'hA0, 2, "R8 empty read");

        // R9: unknown register
        push(8'h5A);
        txn(8'hB0, 2, "R9 unknown reg");
        check("R9 fifo intact", fifo_q.size(), 1);

        // R8 R6: run past the end of the FIFO
        push(8'h77);
        txn(8'hA0, 4, "R8 partial empty");

        // R11: abort after three bits, then fresh decode
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2 * HALF) @(negedge clk);
        for (int i = 7; i >= 5; i--) begin
            sclk = 1'b0;
            mosi = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        cs_n = 1'b1;
        repeat (12) @(negedge clk);
        txn(8'h80, 1, "R11 after abort");

        repeat (10) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule